// File: doc/BRIEF.md
# Dual-Threshold Write Power Monitor

This block watches the laser write power while the drive is recording. Each 8-bit power sample comes with a valid strobe and is tested against two limits. A sample above the upper limit points to a fingerprint or dirt on the disc. A sample below the lower limit points to a laser driver that is not delivering power. Software sets both limits through one register that holds a 4-bit field for each. The block expands each field to a full 8-bit compare value.

The monitor is enabled only during the two recording modes: test-pattern writing and plain writing. The decision is held in a small state machine. `MS_IDLE` means there is no verdict yet, or the monitor is disabled. `MS_CLEAR` means the last sample was inside both limits. `MS_HIGH` means the last sample was above the upper limit only. `MS_LOW` means it was below the lower limit only. `MS_BOTH` means it was outside both limits, which can only happen when the limits are programmed crossed.

The transitions are:
- Deasserting the enable moves any state to `MS_IDLE`.
- A valid sample with the enable high moves any state to the verdict state that matches the comparison.
- Without a valid sample, an enabled monitor stays in its current state.

Each out-of-limit verdict also sets a sticky status bit. The processor clears these bits by writing ones to them.

Top module: `pwr_mon`

## Requirements
- R1: After reset, both live flags and both sticky bits are 0.
- R2: The upper limit is `lim_reg[7:4]` times 16. `over_flag` goes to 1 in the cycle after a valid enabled sample that is strictly greater than this limit, using an unsigned compare. It goes to 0 after a valid enabled sample that is equal or below.
- R3: The lower limit is `lim_reg[3:0]` times 16. `under_flag` goes to 1 in the cycle after a valid enabled sample that is strictly less than this limit, using an unsigned compare. It goes to 0 after a valid enabled sample that is equal or above.
- R4: While the monitor is enabled and `smp_valid` is low, both live flags hold their values, whatever `smp_data` and `lim_reg` do.
- R5: One cycle after `mon_en` is low, both live flags are 0. They stay 0 until the first valid sample that arrives with the monitor enabled.
- R6: A valid enabled sample that raises a live flag also sets the matching sticky bit (`over_sticky` for the upper limit, `under_sticky` for the lower). The sticky bit stays set after the live flag drops.
- R7: A cycle with `clr_wr` high clears `over_sticky` when `clr_mask[0]` is 1 and clears `under_sticky` when `clr_mask[1]` is 1. A mask bit of 0 leaves its sticky bit unchanged.
- R8: When a set and a clear hit the same sticky bit in the same cycle, the set wins and the bit ends up 1.
- R9: While `mon_en` is low, samples are ignored. The sticky bits keep their values, except for processor clears.
- R10: With crossed limits (upper limit below lower limit), a single sample can raise both flags and both sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | High during the recording modes |
| smp_valid | input | 1 | Strobe marking a new power sample |
| smp_data | input | 8 | Unsigned write-power sample |
| lim_reg | input | 8 | Bits 7:4 hold the upper limit field; bits 3:0 hold the lower limit field |
| clr_wr | input | 1 | Processor write strobe for clearing sticky bits |
| clr_mask | input | 2 | Write-one-to-clear mask: bit 0 targets the over bit, bit 1 the under bit |
| over_flag | output | 1 | Live flag: last sample was above the upper limit |
| under_flag | output | 1 | Live flag: last sample was below the lower limit |
| over_sticky | output | 1 | Latched record of an above-limit event |
| under_sticky | output | 1 | Latched record of a below-limit event |

## Verification
The assertions check the following on every cycle:
- Each valid enabled sample is followed one cycle later by the flags and sticky bits its comparison calls for.
- The flags hold while the monitor waits for a sample.
- The flags fall when the monitor is disabled.
- The sticky bits stay unchanged while the monitor is disabled and no clear is written.
- A clear with no competing set empties its bit.

The bench scenarios cover what only a sequence of events can show:
- The exact limit values at the equal and off-by-one boundaries, for several register settings.
- Flags that stay low after re-enabling until a valid sample arrives.
- Partial clears that touch one bit and not the other.
- A sticky bit that outlives its live flag.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_CLEAR,
        MS_HIGH,
        MS_LOW,
        MS_BOTH
    } mon_state_e;

    localparam int FLAG_CNT  = 2;
    localparam int IDX_OVER  = 0;
    localparam int IDX_UNDER = 1;

endpackage

// File: rtl/pm_expand.sv
// Widens a narrow limit field into a sample-width compare value;
// the field lands in the top bits and the low bits are zero.
module pm_expand #(
    parameter int FLD_W = 4,
    parameter int SMP_W = 8
) (
    input  logic [FLD_W-1:0] fld,
    output logic [SMP_W-1:0] lim
);

    localparam int PAD_W = SMP_W - FLD_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign lim = {fld, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign lim = fld[FLD_W-1 -: SMP_W];
        end
    endgenerate

endmodule

// File: rtl/pm_cmp.sv
// Unsigned strict comparisons against both expanded limits.
module pm_cmp #(
    parameter int SMP_W = 8
) (
    input  logic [SMP_W-1:0] smp,
    input  logic [SMP_W-1:0] hi_lim,
    input  logic [SMP_W-1:0] lo_lim,
    output logic             above,
    output logic             below
);

    always_comb begin
        above = (smp > hi_lim);
        below = (smp < lo_lim);
    end

endmodule

// File: rtl/pm_fsm.sv
// Verdict state machine: holds the result of the last accepted sample.
module pm_fsm
    import pm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                valid,
    input  logic                above,
    input  logic                below,
    output logic                over_flag,
    output logic                under_flag,
    output logic [FLAG_CNT-1:0] set_req
);

    mon_state_e state_q;
    mon_state_e state_d;
    logic       take;

    assign take = en && valid;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = MS_IDLE;
        end else if (take) begin
            if (above && below) begin
                state_d = MS_BOTH;
            end else if (above) begin
                state_d = MS_HIGH;
            end else if (below) begin
                state_d = MS_LOW;
            end else begin
                state_d = MS_CLEAR;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        over_flag  = 1'b0;
        under_flag = 1'b0;
        unique case (state_q)
            MS_IDLE:  ;
            MS_CLEAR: ;
            MS_HIGH:  over_flag = 1'b1;
            MS_LOW:   under_flag = 1'b1;
            MS_BOTH: begin
                over_flag  = 1'b1;
                under_flag = 1'b1;
            end
            default: ;
        endcase
    end

    // set strobes for the sticky bank, same cycle as the state update
    always_comb begin
        set_req            = '0;
        set_req[IDX_OVER]  = take && above;
        set_req[IDX_UNDER] = take && below;
    end

endmodule

// File: rtl/pm_sticky.sv
// Bank of sticky bits: set has priority over a write-one-to-clear.
module pm_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] sticky
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sticky[gi] <= 1'b0;
                end else if (set_req[gi]) begin
                    sticky[gi] <= 1'b1;
                end else if (clr_wr && clr_mask[gi]) begin
                    sticky[gi] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pwr_mon.sv
module pwr_mon
    import pm_pkg::*;
#(
    parameter int SMP_W = 8,
    parameter int FLD_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mon_en,
    input  logic                 smp_valid,
    input  logic [SMP_W-1:0]     smp_data,
    input  logic [2*FLD_W-1:0]   lim_reg,
    input  logic                 clr_wr,
    input  logic [FLAG_CNT-1:0]  clr_mask,
    output logic                 over_flag,
    output logic                 under_flag,
    output logic                 over_sticky,
    output logic                 under_sticky
);

    logic [SMP_W-1:0]    hi_lim;
    logic [SMP_W-1:0]    lo_lim;
    logic                above;
    logic                below;
    logic [FLAG_CNT-1:0] set_req;
    logic [FLAG_CNT-1:0] sticky;

    pm_expand #(.FLD_W(FLD_W), .SMP_W(SMP_W)) u_exp_hi (
        .fld (lim_reg[2*FLD_W-1:FLD_W]),
        .lim (hi_lim)
    );

    pm_expand #(.FLD_W(FLD_W), .SMP_W(SMP_W)) u_exp_lo (
        .fld (lim_reg[FLD_W-1:0]),
        .lim (lo_lim)
    );

    pm_cmp #(.SMP_W(SMP_W)) u_cmp (
        .smp    (smp_data),
        .hi_lim (hi_lim),
        .lo_lim (lo_lim),
        .above  (above),
        .below  (below)
    );

    pm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (mon_en),
        .valid      (smp_valid),
        .above      (above),
        .below      (below),
        .over_flag  (over_flag),
        .under_flag (under_flag),
        .set_req    (set_req)
    );

    pm_sticky #(.N(FLAG_CNT)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .sticky   (sticky)
    );

    assign over_sticky  = sticky[IDX_OVER];
    assign under_sticky = sticky[IDX_UNDER];

endmodule

// File: rtl/pwr_mon_chk.sv
module pwr_mon_chk #(
    parameter int SMP_W = 8,
    parameter int FLD_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mon_en,
    input logic               smp_valid,
    input logic [SMP_W-1:0]   smp_data,
    input logic [2*FLD_W-1:0] lim_reg,
    input logic               clr_wr,
    input logic [1:0]         clr_mask,
    input logic               over_flag,
    input logic               under_flag,
    input logic               over_sticky,
    input logic               under_sticky
);

    localparam int PAD_W = SMP_W - FLD_W;

    logic [SMP_W-1:0] hi_ref;
    logic [SMP_W-1:0] lo_ref;
    logic             hit_hi;
    logic             hit_lo;

    assign hi_ref = {lim_reg[2*FLD_W-1:FLD_W], {PAD_W{1'b0}}};
    assign lo_ref = {lim_reg[FLD_W-1:0], {PAD_W{1'b0}}};
    assign hit_hi = mon_en && smp_valid && (smp_data > hi_ref);
    assign hit_lo = mon_en && smp_valid && (smp_data < lo_ref);

    a_r2_over_rise: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi |=> over_flag);

    a_r3_under_rise: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> under_flag);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && !smp_valid) |=> $stable({over_flag, under_flag}));

    a_r5_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!over_flag && !under_flag));

    a_r8_set_over: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi |=> over_sticky);

    a_r8_set_under: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> under_sticky);

    a_r7_clr_over: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[0] && !hit_hi) |=> !over_sticky);

    a_r7_clr_under: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[1] && !hit_lo) |=> !under_sticky);

    a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !clr_wr) |=> $stable({over_sticky, under_sticky}));

endmodule

bind pwr_mon pwr_mon_chk #(.SMP_W(SMP_W), .FLD_W(FLD_W)) u_pwr_mon_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mon_en       (mon_en),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .lim_reg      (lim_reg),
    .clr_wr       (clr_wr),
    .clr_mask     (clr_mask),
    .over_flag    (over_flag),
    .under_flag   (under_flag),
    .over_sticky  (over_sticky),
    .under_sticky (under_sticky)
);

// File: tb/test_pwr_mon.sv
module test_pwr_mon;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_en = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic [7:0] lim_reg = '0;
    logic       clr_wr = 1'b0;
    logic [1:0] clr_mask = '0;
    logic       over_flag;
    logic       under_flag;
    logic       over_sticky;
    logic       under_sticky;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwr_mon i_pwr_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .mon_en       (mon_en),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .lim_reg      (lim_reg),
        .clr_wr       (clr_wr),
        .clr_mask     (clr_mask),
        .over_flag    (over_flag),
        .under_flag   (under_flag),
        .over_sticky  (over_sticky),
        .under_sticky (under_sticky)
    );

    // {sample, limit register, expected over, expected under}
    localparam int NV = 16;
    localparam logic [17:0] VEC [NV] = '{
        {8'd100, 8'hA3, 1'b0, 1'b0},
        {8'd160, 8'hA3, 1'b0, 1'b0},
        {8'd161, 8'hA3, 1'b1, 1'b0},
        {8'd48,  8'hA3, 1'b0, 1'b0},
        {8'd47,  8'hA3, 1'b0, 1'b1},
        {8'd255, 8'hA3, 1'b1, 1'b0},
        {8'd0,   8'hA3, 1'b0, 1'b1},
        {8'd0,   8'h00, 1'b0, 1'b0},
        {8'd1,   8'h00, 1'b1, 1'b0},
        {8'd240, 8'hF0, 1'b0, 1'b0},
        {8'd241, 8'hF0, 1'b1, 1'b0},
        {8'd100, 8'h0F, 1'b1, 1'b1},
        {8'd239, 8'hFF, 1'b0, 1'b1},
        {8'd240, 8'hFF, 1'b0, 1'b0},
        {8'd255, 8'hFF, 1'b1, 1'b0},
        {8'd128, 8'h7F, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic vld, input logic [7:0] d,
                        input logic [7:0] lim, input logic cw, input logic [1:0] cm);
        @(negedge clk);
        mon_en    = en;
        smp_valid = vld;
        smp_data  = d;
        lim_reg   = lim;
        clr_wr    = cw;
        clr_mask  = cm;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 over_flag",    over_flag,    1'b0);
        check("R1 under_flag",   under_flag,   1'b0);
        check("R1 over_sticky",  over_sticky,  1'b0);
        check("R1 under_sticky", under_sticky, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R10 table walk
        for (int i = 0; i < NV; i++) begin
            step(1'b1, 1'b1, VEC[i][17:10], VEC[i][9:2], 1'b0, 2'b00);
            check($sformatf("R2 over vec %0d", i),  over_flag,  VEC[i][1]);
            check($sformatf("R3 under vec %0d", i), under_flag, VEC[i][0]);
        end

        // R4 hold without valid: set over first
        step(1'b1, 1'b1, 8'd161, 8'hA3, 1'b0, 2'b00);
        step(1'b1, 1'b0, 8'd0,   8'hFF, 1'b0, 2'b00);
        check("R4 over held",  over_flag,  1'b1);
        check("R4 under held", under_flag, 1'b0);

        // R6 sticky outlives flag
        step(1'b1, 1'b1, 8'd100, 8'hA3, 1'b0, 2'b00);
        check("R6 over_flag dropped", over_flag,   1'b0);
        check("R6 over_sticky kept",  over_sticky, 1'b1);

        // R5 disable drops flags; R9 sticky kept while disabled
        step(1'b1, 1'b1, 8'd161, 8'hA3, 1'b0, 2'b00);
        step(1'b0, 1'b0, 8'd0, 8'hA3, 1'b0, 2'b00);
        check("R5 over off",        over_flag,   1'b0);
        check("R9 over_sticky kept", over_sticky, 1'b1);
        step(1'b0, 1'b0, 8'd0, 8'hA3, 1'b1, 2'b11);
        check("R7 clear both over",  over_sticky,  1'b0);
        check("R7 clear both under", under_sticky, 1'b0);
        step(1'b0, 1'b1, 8'd0, 8'hA3, 1'b0, 2'b00);
        check("R9 ignored under_flag",   under_flag,   1'b0);
        check("R9 ignored under_sticky", under_sticky, 1'b0);
        step(1'b0, 1'b1, 8'd255, 8'hA3, 1'b0, 2'b00);
        check("R9 ignored over_sticky", over_sticky, 1'b0);

        // R5 re-enable without valid keeps flags low
        step(1'b1, 1'b0, 8'd255, 8'h0F, 1'b0, 2'b00);
        check("R5 reenable over",  over_flag,  1'b0);
        check("R5 reenable under", under_flag, 1'b0);

        // R10 both stickies from one crossed-limit sample
        step(1'b1, 1'b1, 8'd100, 8'h0F, 1'b0, 2'b00);
        check("R10 over_sticky",  over_sticky,  1'b1);
        check("R10 under_sticky", under_sticky, 1'b1);

        // R7 partial clears
        step(1'b1, 1'b0, 8'd100, 8'h0F, 1'b1, 2'b01);
        check("R7 mask0 clears over",  over_sticky,  1'b0);
        check("R7 mask0 keeps under",  under_sticky, 1'b1);
        step(1'b1, 1'b0, 8'd100, 8'h0F, 1'b1, 2'b10);
        check("R7 mask1 clears under", under_sticky, 1'b0);
        step(1'b1, 1'b0, 8'd100, 8'h0F, 1'b1, 2'b00);
        check("R7 mask none", over_sticky | under_sticky, 1'b0);

        // R8 set beats simultaneous clear
        step(1'b1, 1'b1, 8'd161, 8'hA3, 1'b1, 2'b11);
        check("R8 over set wins",  over_sticky,  1'b1);
        check("R8 under cleared",  under_sticky, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule